// File: doc/BRIEF.md
# Motion History Image Updater

This block refreshes a motion history image one pixel at a time. For every pixel it receives three 8-bit values as one stream beat: the pixel of the current grayscale frame, the same pixel of the previous frame, and the history value stored for that pixel. From these it works out whether the pixel moved. A pixel moves when the unsigned magnitude of the frame difference is above a threshold. The block then returns the new history value for that pixel and a one-bit motion-energy flag. A moving pixel reloads its history to the full duration value. A still pixel lets its history fade by one step, and the value never goes below zero.

Each run of the block covers one contiguous segment of the frame in raster order. The segment is given by a start pixel index and a pixel count. Several instances can therefore share one frame, each owning its own segment, and no two of them ever read or write the same pixel. The threshold is captured when a segment starts. The input and output are valid/ready streams. Back-pressure on the output stalls the input, so no pixel is lost. When the last pixel of the segment has left the output, a one-cycle done pulse is raised.

Control is a four-state machine:
- IDLE waits for a start request.
- RUN accepts pixels.
- FLUSH waits for the last result to be taken.
- DONE raises the done pulse.

Transitions:
- IDLE→RUN: start with a non-empty segment.
- IDLE→DONE: start with an empty segment.
- RUN→FLUSH: the final pixel of the segment is accepted.
- FLUSH→DONE: the output register is empty, or is being drained this cycle.
- DONE→IDLE: always, one cycle later.

Top module: `mhi_update_top`

## Requirements
- R1: When a pixel moves, its updated history value is HIST_MAX (default 255), whatever its stored history.
- R2: When a pixel does not move, its updated history is the stored value minus one. A stored value of 0 stays 0.
- R3: A pixel moves only when |cur − prev|, taken as an unsigned 8-bit magnitude, is strictly greater than the threshold. This holds whichever of the two frames is larger. A magnitude equal to the threshold is not motion.
- R4: `out_energy` is 1 exactly when the `out_hist` beat it comes with is non-zero.
- R5: The threshold is sampled on the cycle `start_i` is accepted in IDLE. Later changes to `thresh_i` have no effect on that segment.
- R6: Results leave in input order. Each carries `out_idx` equal to the segment start plus its position, and exactly as many results are produced as the segment's effective count.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the output beat (valid, history, energy, index) is held unchanged.
- R8: `done_o` is a single-cycle pulse. It appears on the cycle after the last result handshake, or on the cycle after the start for an empty segment. `in_ready` is 0 outside the RUN state.
- R9: The effective count is cut at the frame end, which is FRAME_W·FRAME_H pixels. A start index at or past the frame end gives an empty segment.
- R10: After reset, `out_valid`, `in_ready` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a segment (taken in IDLE only) |
| thresh_i | input | 8 | Difference threshold, sampled at start |
| seg_start_i | input | IDX_W | First pixel index of the segment |
| seg_count_i | input | IDX_W | Number of pixels in the segment |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_cur | input | 8 | Current-frame pixel |
| in_prev | input | 8 | Previous-frame pixel |
| in_hist | input | 8 | Stored history value |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Downstream takes the result |
| out_hist | output | 8 | Updated history value |
| out_energy | output | 1 | Motion-energy bit |
| out_idx | output | IDX_W | Pixel index of the result |
| done_o | output | 1 | Segment-complete pulse |

## Verification
The update rule is driven with five pixel patterns, each aimed at one part of the rule:
- Large differences over arbitrary history show the reload to full duration.
- Equal frames over history values of 0, 1 and 255 separate a clamped decrement from a wrapping one.
- Differences set at the threshold and one above it, in both subtraction directions, separate a strict compare from an inclusive one and a signed difference from a magnitude.
- A threshold that changes mid-segment shows whether the value was captured at start.
- Mixed data under three output-stall patterns shows whether stalls drop, duplicate or reorder results.

Segments placed across and beyond the frame end check the clipping of the count.

// File: rtl/mhi_pkg.sv
package mhi_pkg;

    localparam int PIX_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DONE  = 2'd3
    } seg_state_e;

    function automatic logic [PIX_W-1:0] abs_diff(input logic [PIX_W-1:0] a,
                                                   input logic [PIX_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/mhi_pixel_core.sv
module mhi_pixel_core
    import mhi_pkg::*;
#(
    parameter int HIST_MAX = 255
) (
    input  logic [PIX_W-1:0] thr_i,
    input  logic [PIX_W-1:0] cur_i,
    input  logic [PIX_W-1:0] prev_i,
    input  logic [PIX_W-1:0] hist_i,
    output logic             motion_o,
    output logic [PIX_W-1:0] hist_o,
    output logic             energy_o
);

    localparam logic [PIX_W-1:0] FULL = PIX_W'(HIST_MAX);

    logic [PIX_W-1:0] mag;

    always_comb begin
        mag      = abs_diff(cur_i, prev_i);
        motion_o = (mag > thr_i);
        if (motion_o) begin
            hist_o = FULL;
        end else if (hist_i == '0) begin
            hist_o = '0;
        end else begin
            hist_o = hist_i - 1'b1;
        end
        energy_o = (hist_o != '0);
    end

endmodule

// File: rtl/mhi_out_stage.sv
module mhi_out_stage
    import mhi_pkg::*;
#(
    parameter int IDX_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             drain_i,
    input  logic [PIX_W-1:0] d_hist_i,
    input  logic             d_energy_i,
    input  logic [IDX_W-1:0] d_idx_i,
    output logic             space_o,
    output logic             q_valid_o,
    output logic [PIX_W-1:0] q_hist_o,
    output logic             q_energy_o,
    output logic [IDX_W-1:0] q_idx_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid_o  <= 1'b0;
            q_hist_o   <= '0;
            q_energy_o <= 1'b0;
            q_idx_o    <= '0;
        end else if (load_i) begin
            q_valid_o  <= 1'b1;
            q_hist_o   <= d_hist_i;
            q_energy_o <= d_energy_i;
            q_idx_o    <= d_idx_i;
        end else if (drain_i && q_valid_o) begin
            q_valid_o  <= 1'b0;
        end
    end

    assign space_o = !q_valid_o || drain_i;

endmodule

// File: rtl/mhi_seg_ctrl.sv
module mhi_seg_ctrl
    import mhi_pkg::*;
#(
    parameter int TOTAL = 32000,
    parameter int IDX_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PIX_W-1:0] thr_i,
    input  logic [IDX_W-1:0] seg_start_i,
    input  logic [IDX_W-1:0] seg_count_i,
    input  logic             in_valid_i,
    input  logic             space_i,
    input  logic             out_valid_i,
    input  logic             out_ready_i,
    output logic             in_ready_o,
    output logic             accept_o,
    output logic [PIX_W-1:0] thr_q_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] END_IDX = IDX_W'(TOTAL);

    seg_state_e       state_q, state_d;
    logic [IDX_W-1:0] rem_q;
    logic [IDX_W-1:0] avail;
    logic [IDX_W-1:0] eff_count;

    always_comb begin
        if (seg_start_i >= END_IDX) begin
            avail = '0;
        end else begin
            avail = END_IDX - seg_start_i;
        end
        eff_count = (seg_count_i > avail) ? avail : seg_count_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = (eff_count == '0) ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                if (accept_o && rem_q == IDX_W'(1)) begin
                    state_d = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (!out_valid_i || out_ready_i) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready_o = (state_q == ST_RUN) && space_i;
        accept_o   = in_ready_o && in_valid_i;
        done_o     = (state_q == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q_o <= '0;
            idx_o   <= '0;
            rem_q   <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            thr_q_o <= thr_i;
            idx_o   <= seg_start_i;
            rem_q   <= eff_count;
        end else if (accept_o) begin
            idx_o   <= idx_o + 1'b1;
            rem_q   <= rem_q - 1'b1;
        end
    end

endmodule

// File: rtl/mhi_update_top.sv
module mhi_update_top
    import mhi_pkg::*;
#(
    parameter int FRAME_W  = 200,
    parameter int FRAME_H  = 160,
    parameter int HIST_MAX = 255,
    localparam int TOTAL   = FRAME_W * FRAME_H,
    localparam int IDX_W   = $clog2(TOTAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       thresh_i,
    input  logic [IDX_W-1:0] seg_start_i,
    input  logic [IDX_W-1:0] seg_count_i,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_cur,
    input  logic [7:0]       in_prev,
    input  logic [7:0]       in_hist,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_hist,
    output logic             out_energy,
    output logic [IDX_W-1:0] out_idx,
    output logic             done_o
);

    logic             accept;
    logic             space;
    logic [PIX_W-1:0] thr_q;
    logic [IDX_W-1:0] idx_cur;
    logic             motion;
    logic [PIX_W-1:0] hist_new;
    logic             energy_new;

    mhi_seg_ctrl #(
        .TOTAL (TOTAL),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .thr_i       (thresh_i),
        .seg_start_i (seg_start_i),
        .seg_count_i (seg_count_i),
        .in_valid_i  (in_valid),
        .space_i     (space),
        .out_valid_i (out_valid),
        .out_ready_i (out_ready),
        .in_ready_o  (in_ready),
        .accept_o    (accept),
        .thr_q_o     (thr_q),
        .idx_o       (idx_cur),
        .done_o      (done_o)
    );

    mhi_pixel_core #(
        .HIST_MAX (HIST_MAX)
    ) u_core (
        .thr_i    (thr_q),
        .cur_i    (in_cur),
        .prev_i   (in_prev),
        .hist_i   (in_hist),
        .motion_o (motion),
        .hist_o   (hist_new),
        .energy_o (energy_new)
    );

    mhi_out_stage #(
        .IDX_W (IDX_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .drain_i    (out_ready),
        .d_hist_i   (hist_new),
        .d_energy_i (energy_new),
        .d_idx_i    (idx_cur),
        .space_o    (space),
        .q_valid_o  (out_valid),
        .q_hist_o   (out_hist),
        .q_energy_o (out_energy),
        .q_idx_o    (out_idx)
    );

    logic unused_motion;
    assign unused_motion = motion;

endmodule

// File: rtl/mhi_update_chk.sv
module mhi_update_chk #(
    parameter int IDX_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_hist,
    input logic             out_energy,
    input logic [IDX_W-1:0] out_idx,
    input logic             done_o
);

    logic             have_prev;
    logic [IDX_W-1:0] last_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            last_idx  <= '0;
        end else if (done_o) begin
            have_prev <= 1'b0;
        end else if (out_valid && out_ready) begin
            have_prev <= 1'b1;
            last_idx  <= out_idx;
        end
    end

    // R7: a stalled output blocks the input side
    a_r7_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R7: a stalled beat stays put
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_hist)
                                       && $stable(out_energy) && $stable(out_idx)));

    // R4: energy flag agrees with the history beat it travels with
    a_r4_energy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_energy == (out_hist != 8'd0)));

    // R8: done lasts one cycle and the input is closed meanwhile
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_closed_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !in_ready);

    // R6: consecutive results in a segment have consecutive indices
    a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && have_prev) |-> (out_idx == last_idx + 1'b1));

endmodule

bind mhi_update_top mhi_update_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_hist   (out_hist),
    .out_energy (out_energy),
    .out_idx    (out_idx),
    .done_o     (done_o)
);

// File: tb/mhi_update_top_tb.sv
`timescale 1ns/100ps
module mhi_update_top_tb;

    localparam int FW  = 200;
    localparam int FH  = 160;
    localparam int TOT = FW * FH;
    localparam int IW  = $clog2(TOT + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [7:0]    thresh_i = '0;
    logic [IW-1:0] seg_start_i = '0;
    logic [IW-1:0] seg_count_i = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_cur = '0, in_prev = '0, in_hist = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [7:0]    out_hist;
    logic          out_energy;
    logic [IW-1:0] out_idx;
    logic          done_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [7:0] cur_a [64];
    logic [7:0] prev_a[64];
    logic [7:0] hist_a[64];

    always #2.5 clk = ~clk;

    mhi_update_top u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .thresh_i(thresh_i),
        .seg_start_i(seg_start_i), .seg_count_i(seg_count_i),
        .in_valid(in_valid), .in_ready(in_ready), .in_cur(in_cur),
        .in_prev(in_prev), .in_hist(in_hist), .out_valid(out_valid),
        .out_ready(out_ready), .out_hist(out_hist), .out_energy(out_energy),
        .out_idx(out_idx), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int model(input int c, input int p, input int h, input int t);
        int d;
        d = (c > p) ? c - p : p - c;
        if (d > t) return 255;
        return (h == 0) ? 0 : h - 1;
    endfunction

    task automatic fill(input int mode, input int thr);
        for (int k = 0; k < 64; k++) begin
            case (mode)
                0: begin cur_a[k] = 8'd200; prev_a[k] = 8'(k * 3); hist_a[k] = 8'(k * 7); end
                1: begin
                    cur_a[k] = 8'(k * 13); prev_a[k] = 8'(k * 13);
                    hist_a[k] = (k % 4 == 0) ? 8'd0 : (k % 4 == 1) ? 8'd1
                              : (k % 4 == 2) ? 8'd255 : 8'(k * 9);
                end
                2: begin
                    hist_a[k] = 8'(k * 5 + 1);
                    case (k % 4)
                        0: begin prev_a[k] = 8'(50 + k); cur_a[k] = 8'(50 + k + thr); end
                        1: begin prev_a[k] = 8'(50 + k); cur_a[k] = 8'(50 + k + thr + 1); end
                        2: begin cur_a[k] = 8'(50 + k); prev_a[k] = 8'(50 + k + thr + 1); end
                        default: begin cur_a[k] = 8'(50 + k); prev_a[k] = 8'(50 + k + thr); end
                    endcase
                end
                default: begin
                    cur_a[k] = 8'(k * 37 + 11); prev_a[k] = 8'(k * 53 + 3); hist_a[k] = 8'(k * 29);
                end
            endcase
        end
    endtask

    task automatic run_seg(input int start, input int count, input int thr,
                           input int thr_late, input int stall, input string req);
        int n, sent, recv, last_hs, cyc, exp_h;
        bit done_seen;
        n = (start >= TOT) ? 0 : ((count > TOT - start) ? TOT - start : count);
        @(negedge clk);
        start_i = 1'b1; seg_start_i = IW'(start); seg_count_i = IW'(count);
        thresh_i = 8'(thr);
        @(negedge clk);
        start_i = 1'b0; thresh_i = 8'(thr_late);
        sent = 0; recv = 0; last_hs = -1; cyc = 0; done_seen = 0;
        while (!done_seen && cyc < 2000) begin
            case (stall)
                0: out_ready = 1'b1;
                1: out_ready = (cyc % 2 == 0);
                default: out_ready = ((cyc % 5) >= 3);
            endcase
            in_valid = (sent < n);
            if (sent < n) begin
                in_cur = cur_a[sent]; in_prev = prev_a[sent]; in_hist = hist_a[sent];
            end
            #1;
            if (done_o) begin
                done_seen = 1;
                chk(cyc == last_hs + 1, "R8", "done cycle", cyc, last_hs + 1);
                chk(!in_ready, "R8", "in_ready at done", int'(in_ready), 0);
            end else begin
                if (out_valid && !out_ready)
                    chk(!in_ready, "R7", "in_ready during stall", int'(in_ready), 0);
                if (out_valid && out_ready) begin
                    exp_h = model(cur_a[recv], prev_a[recv], hist_a[recv], thr);
                    chk(int'(out_hist) == exp_h, req, "history", int'(out_hist), exp_h);
                    chk(out_energy == (exp_h != 0), "R4", "energy",
                        int'(out_energy), int'(exp_h != 0));
                    chk(int'(out_idx) == start + recv, "R6", "index",
                        int'(out_idx), start + recv);
                    recv++;
                    last_hs = cyc;
                end
                if (in_valid && in_ready) sent++;
            end
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0; out_ready = 1'b0;
        chk(done_seen, "R8", "done seen", int'(done_seen), 1);
        chk(recv == n, (start + count > TOT) ? "R9" : "R6", "result count", recv, n);
        #1;
        chk(!done_o, "R8", "done pulse width", int'(done_o), 0);
    endtask

    task automatic t_reset();
        #1;
        chk(!out_valid && !in_ready && !done_o, "R10", "reset outputs",
            int'({out_valid, in_ready, done_o}), 0);
    endtask

    task automatic t_motion();     fill(0, 20); run_seg(0, 16, 20, 20, 0, "R1"); endtask
    task automatic t_decay();      fill(1, 10); run_seg(100, 16, 10, 10, 0, "R2"); endtask
    task automatic t_thresh_edge(); fill(2, 40); run_seg(500, 16, 40, 40, 0, "R3"); endtask
    task automatic t_thr_late();   fill(2, 40); run_seg(900, 12, 40, 0, 0, "R5"); endtask
    task automatic t_stall_alt();  fill(3, 60); run_seg(2000, 20, 60, 60, 1, "R7"); endtask
    task automatic t_stall_burst(); fill(3, 60); run_seg(3000, 24, 60, 60, 2, "R7"); endtask
    task automatic t_clip();       fill(3, 60); run_seg(TOT - 10, 20, 60, 60, 1, "R9"); endtask
    task automatic t_past_end();   run_seg(TOT, 5, 60, 60, 0, "R9"); endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_motion();
        t_decay();
        t_thresh_edge();
        t_thr_late();
        t_stall_alt();
        t_stall_burst();
        t_clip();
        t_past_end();
        finished = 1;
    end

    initial begin
        int cycles;
        cycles = 0;
        while (!finished && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cycles, 100000);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule